// File: doc/BRIEF.md
# Step Event Spacing Enforcer

The block sits between a source of single-step position events and the quadrature output stage. Each cycle it may receive one step event with a direction bit. It makes sure that two released events are never closer together than a programmable number of clock cycles. An event that breaks this spacing is not dropped. The block holds it back and releases it as soon as the spacing allows. An event that arrives after the spacing has already run out is passed on with no extra wait beyond the fixed output register.

The spacing in cycles is the product of two settings. The first is a 16-bit base gap. The second is a power-of-two divisor that the downstream pulse divider applies. That divisor is 1 for interpolation factors 10, 12 and 16, 2 for factors 5 and 8, 4 for factors 3 and 4, 8 for factor 2, and 16 for factor 1. Held events are stored as a signed net count. Steps that arrive in the opposite direction while the count is non-zero cancel against it. The count saturates at its largest magnitude. When it saturates, a sticky overflow flag is set.

Top module: `step_spacer`

## Requirements
- R1: While reset is asserted and right after it, `step_out`, `pending` and `overflow` are 0.
- R2: If no events are held and the spacing has run out, an event sampled at a clock edge appears on `step_out` at that same edge, with `step_out_dir` equal to its direction. This is a latency of exactly one cycle.
- R3: Two consecutive `step_out` pulses are at least G cycles apart. G is `gap_cfg` multiplied by the divisor, and the spacing is never less than one cycle. A held event is released exactly G cycles after the previous release.
- R4: `div_sel` values 0, 1, 2, 3 and 4 select divisors 1, 2, 4, 8 and 16. Values 5 to 7 select 16.
- R5: When G is 0 or 1, every event passes with one cycle of latency, and back-to-back events give back-to-back outputs.
- R6: Held events come out in arrival order, each with its own direction. This also holds when a release and a new event of the opposite direction fall on the same cycle.
- R7: An event whose direction is opposite to the sign of a non-zero held count, and that is not released, reduces the count and produces no output.
- R8: With 8-bit count storage, the held count saturates at +127 and at -127. An event that would go past the limit is discarded and sets `overflow`, which stays at 1 until reset.
- R9: `pending` is 1 exactly when the held count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_in | input | 1 | One step event in this cycle |
| step_dir | input | 1 | Direction of the event: 1 up, 0 down |
| gap_cfg | input | 16 | Base minimum spacing in cycles |
| div_sel | input | 3 | Divisor select (log2 of the divisor) |
| step_out | output | 1 | Released step event |
| step_out_dir | output | 1 | Direction of the released event |
| pending | output | 1 | Events are being held |
| overflow | output | 1 | Sticky flag: saturation dropped an event |

## Verification
The bench sweeps every divisor code over several base gaps, and sweeps the arrival distance of a second event across the spacing boundary. A design that scaled the gap wrongly, treated codes 5 to 7 badly, or released one cycle early or late would show a spacing that differs from the product. The bench also aims at three corners: a release and an opposite-direction arrival in the same cycle, where a design that cancelled instead of queueing would lose an event or swap the order; cancellation inside the gap, where a spurious pulse or a stuck `pending` would appear; and saturation at both signs. In the saturation case, counting one event too many, wrapping the count, or clearing the flag once the count drains would change the number of drained pulses or the state of the flag.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

    // Clamp a divisor select code to the largest supported shift.
    function automatic int clamp_shift(input int sel, input int max_log);
        return (sel > max_log) ? max_log : sel;
    endfunction

endpackage

// File: rtl/spc_div_decode.sv
module spc_div_decode #(
    parameter int SEL_W   = 3,
    parameter int MAX_LOG = 4,
    localparam int SH_W   = $clog2(MAX_LOG + 1)
) (
    input  logic [SEL_W-1:0] sel,
    output logic [SH_W-1:0]  shift
);

    always_comb begin
        shift = '0;
        for (int i = 0; i <= MAX_LOG; i++) begin
            if (int'(sel) == i) shift = SH_W'(i);
        end
        if (int'(sel) > MAX_LOG) shift = SH_W'(spc_pkg::clamp_shift(int'(sel), MAX_LOG));
    end

endmodule

// File: rtl/spc_gap_timer.sv
module spc_gap_timer #(
    parameter int TMR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             ready
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign ready = (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (!ready) begin
            tmr_d.cnt = tmr_q.cnt - TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/spc_backlog.sv
module spc_backlog #(
    parameter int BL_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic evt,
    input  logic evt_dir,
    output logic rel,
    output logic rel_dir,
    output logic nonzero,
    output logic ovf
);

    localparam logic signed [BL_W-1:0] ONE     = BL_W'(1);
    localparam logic signed [BL_W-1:0] POS_MAX = {1'b0, {(BL_W-1){1'b1}}};
    localparam logic signed [BL_W-1:0] NEG_MAX = ~POS_MAX + ONE;

    typedef struct packed {
        logic [BL_W-1:0] cnt;
        logic            ovf;
    } bl_t;

    bl_t bl_d, bl_q;
    logic signed [BL_W-1:0] net;

    assign nonzero = (bl_q.cnt != '0);
    assign ovf     = bl_q.ovf;

    always_comb begin
        bl_d    = bl_q;
        rel     = 1'b0;
        rel_dir = spc_pkg::DIR_DOWN;
        net     = $signed(bl_q.cnt);
        // The oldest held event leaves first.
        if (ready && nonzero) begin
            rel     = 1'b1;
            rel_dir = ~bl_q.cnt[BL_W-1];
            net     = bl_q.cnt[BL_W-1] ? net + ONE : net - ONE;
        end
        if (evt) begin
            if (ready && !nonzero) begin
                rel     = 1'b1;
                rel_dir = evt_dir;
            end else if (evt_dir == spc_pkg::DIR_UP) begin
                if (net == POS_MAX) bl_d.ovf = 1'b1;
                else                net      = net + ONE;
            end else begin
                if (net == NEG_MAX) bl_d.ovf = 1'b1;
                else                net      = net - ONE;
            end
        end
        bl_d.cnt = net;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bl_q <= '0;
        else        bl_q <= bl_d;
    end

endmodule

// File: rtl/step_spacer.sv
module step_spacer #(
    parameter int GAP_W       = 16,
    parameter int DIV_SEL_W   = 3,
    parameter int MAX_DIV_LOG = 4,
    parameter int BL_W        = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_in,
    input  logic                 step_dir,
    input  logic [GAP_W-1:0]     gap_cfg,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 step_out,
    output logic                 step_out_dir,
    output logic                 pending,
    output logic                 overflow
);

    localparam int TMR_W = GAP_W + MAX_DIV_LOG;
    localparam int SH_W  = $clog2(MAX_DIV_LOG + 1);

    typedef struct packed {
        logic vld;
        logic dir;
    } out_t;

    out_t             out_d, out_q;
    logic [SH_W-1:0]  shift;
    logic [TMR_W-1:0] eff_gap;
    logic [TMR_W-1:0] load_val;
    logic             ready;
    logic             rel;
    logic             rel_dir;

    spc_div_decode #(
        .SEL_W   (DIV_SEL_W),
        .MAX_LOG (MAX_DIV_LOG)
    ) u_div (
        .sel   (div_sel),
        .shift (shift)
    );

    assign eff_gap  = TMR_W'(gap_cfg) << shift;
    assign load_val = (eff_gap > TMR_W'(1)) ? eff_gap - TMR_W'(1) : '0;

    spc_gap_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rel),
        .load_val (load_val),
        .ready    (ready)
    );

    spc_backlog #(
        .BL_W (BL_W)
    ) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready   (ready),
        .evt     (step_in),
        .evt_dir (step_dir),
        .rel     (rel),
        .rel_dir (rel_dir),
        .nonzero (pending),
        .ovf     (overflow)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = rel;
        out_d.dir = rel ? rel_dir : out_q.dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign step_out     = out_q.vld;
    assign step_out_dir = out_q.dir;

endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int GAP_W       = 16,
    parameter int DIV_SEL_W   = 3,
    parameter int MAX_DIV_LOG = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 step_in,
    input logic                 step_dir,
    input logic [GAP_W-1:0]     gap_cfg,
    input logic [DIV_SEL_W-1:0] div_sel,
    input logic                 step_out,
    input logic                 step_out_dir,
    input logic                 pending,
    input logic                 overflow
);

    localparam int TMR_W = GAP_W + MAX_DIV_LOG;

    function automatic logic [TMR_W-1:0] scaled(input logic [GAP_W-1:0] g,
                                                input logic [DIV_SEL_W-1:0] s);
        return TMR_W'(g) << spc_pkg::clamp_shift(int'(s), MAX_DIV_LOG);
    endfunction

    logic [GAP_W-1:0]     gap_prev;
    logic [DIV_SEL_W-1:0] div_prev;
    logic [TMR_W-1:0]     since_q;
    logic                 valid_q;
    logic                 cfg_chg;
    logic [TMR_W-1:0]     g_now;
    logic [TMR_W-1:0]     g_prev;

    assign cfg_chg = (gap_cfg != gap_prev) || (div_sel != div_prev);
    assign g_now   = scaled(gap_cfg, div_sel);
    assign g_prev  = scaled(gap_prev, div_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_prev <= '0;
            div_prev <= '0;
            since_q  <= '1;
            valid_q  <= 1'b0;
        end else begin
            gap_prev <= gap_cfg;
            div_prev <= div_sel;
            if (step_out)          since_q <= TMR_W'(1);
            else if (~&since_q)    since_q <= since_q + TMR_W'(1);
            if (cfg_chg)           valid_q <= 1'b0;
            else if (step_out)     valid_q <= 1'b1;
        end
    end

    // R2: an output pulse needs an incoming event or a held one
    assert_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_out |-> ($past(step_in) || $past(pending)));

    // R3: spacing under a stable configuration
    assert_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_out && valid_q) |-> (since_q >= g_prev));

    // R5: no spacing means back-to-back pass-through
    assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_in && step_out && !pending && g_now <= TMR_W'(1) && g_prev <= TMR_W'(1))
        |=> (step_out && step_out_dir == $past(step_dir)));

    // R8: overflow is sticky
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9: saturation only happens with a held count
    assert_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> pending);

endmodule

bind step_spacer spc_checker #(
    .GAP_W       (GAP_W),
    .DIV_SEL_W   (DIV_SEL_W),
    .MAX_DIV_LOG (MAX_DIV_LOG)
) u_spc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_in      (step_in),
    .step_dir     (step_dir),
    .gap_cfg      (gap_cfg),
    .div_sel      (div_sel),
    .step_out     (step_out),
    .step_out_dir (step_out_dir),
    .pending      (pending),
    .overflow     (overflow)
);

// File: tb/step_spacer_bench.sv
`timescale 1ns/1ps
module step_spacer_bench;

    localparam int LOG_N  = 1024;
    localparam int MAXMAG = 127;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_in = 1'b0;
    logic        step_dir = 1'b0;
    logic [15:0] gap_cfg = '0;
    logic [2:0]  div_sel = '0;
    logic        step_out, step_out_dir, pending, overflow;

    longint cyc = 0;
    longint log_cyc [LOG_N];
    bit     log_dir [LOG_N];
    int     nlog = 0;
    int     n_tests = 0;
    int     n_fail = 0;
    bit     timed_out = 1'b0;

    always #5 clk = ~clk;

    step_spacer u_step_spacer (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .step_dir(step_dir),
        .gap_cfg(gap_cfg), .div_sel(div_sel), .step_out(step_out),
        .step_out_dir(step_out_dir), .pending(pending), .overflow(overflow)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && step_out && nlog < LOG_N) begin
            log_cyc[nlog] = cyc;
            log_dir[nlog] = step_out_dir;
            nlog = nlog + 1;
        end
    end

    function automatic longint exp_gap(input int g, input int s);
        int sh;
        sh = (s > 4) ? 4 : s;
        return longint'(g) * (longint'(1) << sh);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        step_in = 1'b0;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input bit d);
        step_in  = 1'b1;
        step_dir = d;
        @(negedge clk);
        step_in = 1'b0;
    endtask

    task automatic run_all();
        int     base;
        longint t0, g, sp, ex;
        int     gaps [5] = '{0, 1, 2, 3, 7};
        bit     pat [5]  = '{1, 1, 1, 0, 0};
        bit     pend [5] = '{0, 1, 1, 1, 0};

        // R1 reset state
        repeat (2) @(negedge clk);
        chk(!step_out && !pending && !overflow, "R1", "outputs during reset",
            {step_out, pending, overflow}, 0);
        do_reset();
        chk(!step_out && !pending && !overflow, "R1", "outputs after reset",
            {step_out, pending, overflow}, 0);

        // Sweep: every divisor code over several base gaps, two back-to-back events
        foreach (gaps[gi]) begin
            for (int s = 0; s < 8; s++) begin
                gap_cfg = 16'(gaps[gi]);
                div_sel = 3'(s);
                do_reset();
                g  = exp_gap(gaps[gi], s);
                sp = (g < 1) ? 1 : g;
                base = nlog;
                t0 = cyc;
                step_in = 1'b1; step_dir = 1'b1;
                @(negedge clk);
                step_dir = 1'b0;
                @(negedge clk);
                step_in = 1'b0;
                repeat (int'(sp) + 4) @(negedge clk);
                chk(nlog - base == 2, "R4", "pulse count", nlog - base, 2);
                if (nlog - base >= 2) begin
                    chk(log_cyc[base] - t0 == 1, "R2", "first latency", log_cyc[base] - t0, 1);
                    chk(log_cyc[base+1] - log_cyc[base] == sp, (g <= 1) ? "R5" : "R3",
                        "spacing", log_cyc[base+1] - log_cyc[base], sp);
                    chk(log_dir[base] == 1'b1 && log_dir[base+1] == 1'b0, "R6",
                        "directions", {log_dir[base], log_dir[base+1]}, 2);
                end
            end
        end

        // Arrival distance sweep across the spacing boundary (G = 5 * 2 = 10)
        for (int k = 1; k <= 13; k++) begin
            gap_cfg = 16'd5; div_sel = 3'd1;
            do_reset();
            base = nlog;
            t0 = cyc;
            pulse(1'b1);
            repeat (k - 1) @(negedge clk);
            pulse(1'b1);
            repeat (20) @(negedge clk);
            ex = (k > 10) ? k : 10;
            chk(nlog - base == 2, "R3", "pulse count", nlog - base, 2);
            if (nlog - base >= 2)
                chk(log_cyc[base+1] - t0 == 1 + ex, (k >= 10) ? "R2" : "R3",
                    "second release cycle", log_cyc[base+1] - t0, 1 + ex);
        end

        // Order: one direct, three queued of the other sign (G = 4)
        for (int fd = 0; fd < 2; fd++) begin
            gap_cfg = 16'd4; div_sel = 3'd0;
            do_reset();
            base = nlog;
            t0 = cyc;
            step_in = 1'b1; step_dir = 1'(fd);
            @(negedge clk);
            step_dir = ~1'(fd);
            repeat (3) @(negedge clk);
            step_in = 1'b0;
            repeat (20) @(negedge clk);
            chk(nlog - base == 4, "R6", "queued count", nlog - base, 4);
            for (int i = 0; i < 4 && base + i < nlog; i++) begin
                chk(log_cyc[base+i] - t0 == 1 + 4 * i, "R6", "release cycle",
                    log_cyc[base+i] - t0, 1 + 4 * i);
                chk(log_dir[base+i] == ((i == 0) ? 1'(fd) : ~1'(fd)), "R6", "release dir",
                    log_dir[base+i], (i == 0) ? fd : 1 - fd);
            end
        end

        // Release and opposite arrival in the same cycle (G = 4): up@0, down@1, up@4
        gap_cfg = 16'd4; div_sel = 3'd0;
        do_reset();
        base = nlog;
        t0 = cyc;
        pulse(1'b1);
        pulse(1'b0);
        repeat (2) @(negedge clk);
        pulse(1'b1);
        repeat (20) @(negedge clk);
        chk(nlog - base == 3, "R6", "same-cycle count", nlog - base, 3);
        if (nlog - base >= 3) begin
            chk(log_cyc[base+1] - t0 == 5 && log_dir[base+1] == 1'b0, "R6",
                "second release", log_cyc[base+1] - t0, 5);
            chk(log_cyc[base+2] - t0 == 9 && log_dir[base+2] == 1'b1, "R6",
                "third release", log_cyc[base+2] - t0, 9);
        end

        // Cancellation inside the gap (G = 20)
        gap_cfg = 16'd20; div_sel = 3'd0;
        do_reset();
        base = nlog;
        for (int i = 0; i < 5; i++) begin
            step_in = 1'b1; step_dir = pat[i];
            @(negedge clk);
            chk(pending == pend[i], "R9", "pending during burst", pending, pend[i]);
        end
        step_in = 1'b0;
        repeat (40) @(negedge clk);
        chk(nlog - base == 1, "R7", "pulses after cancel", nlog - base, 1);
        chk(!pending, "R7", "pending after cancel", pending, 0);

        // Positive saturation and drain (G = 200)
        gap_cfg = 16'd200; div_sel = 3'd0;
        do_reset();
        base = nlog;
        step_in = 1'b1; step_dir = 1'b1;
        repeat (MAXMAG + 1) @(negedge clk);
        chk(!overflow && pending, "R8", "at limit, no overflow", overflow, 0);
        @(negedge clk);
        step_in = 1'b0;
        chk(overflow, "R8", "overflow past limit", overflow, 1);
        repeat (MAXMAG * 200 + 300) @(negedge clk);
        chk(nlog - base == MAXMAG + 1, "R8", "drained pulses", nlog - base, MAXMAG + 1);
        chk(overflow, "R8", "overflow sticky after drain", overflow, 1);
        chk(!pending, "R9", "pending after drain", pending, 0);
        do_reset();
        chk(!overflow, "R1", "overflow cleared by reset", overflow, 0);

        // Negative saturation
        step_in = 1'b1; step_dir = 1'b0;
        repeat (MAXMAG + 1) @(negedge clk);
        chk(!overflow, "R8", "negative limit, no overflow", overflow, 0);
        @(negedge clk);
        step_in = 1'b0;
        chk(overflow && pending, "R8", "negative overflow", {overflow, pending}, 3);
        do_reset();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule